// File: doc/BRIEF.md
# BCD Time-of-Day and Date Counter

This block keeps wall-clock time and calendar date as packed BCD words. A two-stage prescaler (a short asynchronous stage followed by a long synchronous stage) divides the RTC kernel clock down to a once-per-second step. Each step advances the seconds. Carries then ripple through minutes, hours, day of month, month and a two-digit year. A weekday code runs alongside the day count. Only 24-hour time is kept.

Software enters initialization mode to set the clock. While that mode is held, the calendar and the prescaler are frozen, and a load strobe copies the time and date load words into the counters. A status flag shows whether the calendar holds a nonzero year, which means it has been set since power-up. When initialization mode is released, the prescaler restarts from zero.

Top module: `cal_bcd_top`

## Requirements
- R1: After reset the time word is 0x000000 (00:00:00), the date word reads day 0x01, month 0x01, weekday 1 and year 0x00, `initDone` is 0 and `secTick` is 0.
- R2: The prescaler word carries the synchronous divider S in bits 14:0 and the asynchronous divider A in bits 22:16. Outside initialization mode the calendar steps once every (A+1)*(S+1) clocks, counted from reset or from the last exit from initialization mode. `secTick` is high for exactly the one cycle in which each new value first appears.
- R3: The time word holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the date, so the hour never reads above 23.
- R4: The date word holds BCD day in bits 5:0, month in bits 12:8, weekday in bits 15:13 and year in bits 23:16. After the last day of a month the day returns to 01 and the month advances. April, June, September and November end on day 30; all other months except February end on day 31.
- R5: February ends on day 29 when the BCD year is divisible by four, and on day 28 otherwise.
- R6: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R7: The weekday code (1 = Monday through 7 = Sunday) advances on every day change and wraps from 7 to 1.
- R8: A load strobe given outside initialization mode has no effect on the time word, the date word or `initDone`.
- R9: While initialization mode is high, the time and date do not advance and `secTick` stays low. A load strobe in that mode replaces both words at the next clock edge.
- R10: `initDone` is 1 exactly when the year field is nonzero. It changes in the same cycle as the year field, whether the year changes by a load or by a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initMode | input | 1 | Initialization mode: freezes counting, enables loads |
| prescWord | input | 23 | Divider settings, S in 14:0, A in 22:16 |
| timeLoad | input | 22 | Packed BCD time to load |
| dateLoad | input | 24 | Packed BCD date to load |
| loadStrobe | input | 1 | Load request, honoured only in initialization mode |
| timeWord | output | 22 | Packed BCD time |
| dateWord | output | 24 | Packed BCD date |
| secTick | output | 1 | One-cycle pulse marking each calendar step |
| initDone | output | 1 | Year field is nonzero |

## Verification
Every result follows its cause by exactly one clock edge. A load shows up after the edge that samples the strobe. A step shows up after the edge at which the prescaler total reaches (A+1)*(S+1), and `secTick` rises in that same cycle. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge, using a single product counter in place of two nested counters. It compares every output with that model on the following falling edge, so each comparison falls in the cycle where the result is due. Rollover cases are reached by loading values one or two seconds before each boundary.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef struct packed {
    logic advance;
    logic load;
  } calStrobes_t;

  localparam int TIME_W = 22;
  localparam int DATE_W = 24;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcdInc = {v[7:4] + 4'h1, 4'h0};
    else bcdInc = {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    if (yr[4]) isLeap = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    else isLeap = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: lastDay = isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default: lastDay = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initMode,
  input  logic               loadStrobe,
  input  logic [ASYNC_W-1:0] asyncDiv,
  input  logic [SYNC_W-1:0]  syncDiv,
  output calStrobes_t        strobes,
  output logic               secTick
);
  logic [ASYNC_W-1:0] asyncCnt;
  logic [SYNC_W-1:0]  syncCnt;
  logic asyncLast, syncLast;

  assign asyncLast = asyncCnt >= asyncDiv;
  assign syncLast  = syncCnt >= syncDiv;

  always_comb begin
    strobes.advance = !initMode && asyncLast && syncLast;
    strobes.load    = initMode && loadStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asyncCnt <= '0;
      syncCnt  <= '0;
      secTick  <= 1'b0;
    end else begin
      secTick <= strobes.advance;
      if (initMode) begin
        asyncCnt <= '0;
        syncCnt  <= '0;
      end else if (asyncLast) begin
        asyncCnt <= '0;
        syncCnt  <= syncLast ? '0 : syncCnt + 1'b1;
      end else begin
        asyncCnt <= asyncCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic [TIME_W-1:0] timeLoad,
  input  logic [DATE_W-1:0] dateLoad,
  output logic [TIME_W-1:0] timeWord,
  output logic [DATE_W-1:0] dateWord,
  output logic              initDone
);
  logic [7:0] sec, min, hour, day, month, year;
  logic [2:0] wday;
  logic cMin, cHour, cDay, cMon, cYear;
  logic [7:0] yearN;

  always_comb begin
    cMin  = sec == 8'h59;
    cHour = cMin && (min == 8'h59);
    cDay  = cHour && (hour == 8'h23);
    cMon  = cDay && (day == lastDay(month, year));
    cYear = cMon && (month == 8'h12);
    yearN = (year == 8'h99) ? 8'h00 : bcdInc(year);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= 8'h00; min <= 8'h00; hour <= 8'h00;
      day <= 8'h01; month <= 8'h01; wday <= 3'd1; year <= 8'h00;
      initDone <= 1'b0;
    end else if (strobes.load) begin
      sec   <= {1'b0, timeLoad[6:0]};
      min   <= {1'b0, timeLoad[14:8]};
      hour  <= {2'b0, timeLoad[21:16]};
      day   <= {2'b0, dateLoad[5:0]};
      month <= {3'b0, dateLoad[12:8]};
      wday  <= dateLoad[15:13];
      year  <= dateLoad[23:16];
      initDone <= dateLoad[23:16] != 8'h00;
    end else if (strobes.advance) begin
      sec <= cMin ? 8'h00 : bcdInc(sec);
      if (cMin) min <= cHour ? 8'h00 : bcdInc(min);
      if (cHour) hour <= cDay ? 8'h00 : bcdInc(hour);
      if (cDay) begin
        day  <= cMon ? 8'h01 : bcdInc(day);
        wday <= (wday == 3'd7) ? 3'd1 : wday + 3'd1;
      end
      if (cMon) month <= cYear ? 8'h01 : bcdInc(month);
      if (cYear) begin
        year     <= yearN;
        initDone <= yearN != 8'h00;
      end
    end
  end

  assign timeWord = {hour[5:0], 1'b0, min[6:0], 1'b0, sec[6:0]};
  assign dateWord = {year, wday, month[4:0], 2'b00, day[5:0]};
endmodule

// File: rtl/cal_bcd_top.sv
module cal_bcd_top
  import cal_pkg::*;
#(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15,
  localparam int ASYNC_LSB = 16,
  localparam int PRESC_W = ASYNC_LSB + ASYNC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initMode,
  input  logic [PRESC_W-1:0] prescWord,
  input  logic [TIME_W-1:0]  timeLoad,
  input  logic [DATE_W-1:0]  dateLoad,
  input  logic               loadStrobe,
  output logic [TIME_W-1:0]  timeWord,
  output logic [DATE_W-1:0]  dateWord,
  output logic               secTick,
  output logic               initDone
);
  calStrobes_t strobes;
  logic [ASYNC_LSB-1:0] unusedGap;
  assign unusedGap = prescWord[ASYNC_LSB-1:0];

  cal_ctrl #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) ctrl (
    .clk(clk), .rstN(rstN), .initMode(initMode), .loadStrobe(loadStrobe),
    .asyncDiv(prescWord[PRESC_W-1:ASYNC_LSB]),
    .syncDiv(unusedGap[SYNC_W-1:0]),
    .strobes(strobes), .secTick(secTick)
  );

  cal_datapath datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .timeLoad(timeLoad), .dateLoad(dateLoad),
    .timeWord(timeWord), .dateWord(dateWord), .initDone(initDone)
  );
endmodule

// File: rtl/cal_bcd_chk.sv
module cal_bcd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        initMode,
  input logic        loadStrobe,
  input logic [21:0] timeWord,
  input logic [23:0] dateWord,
  input logic        secTick,
  input logic        initDone
);
  // R9
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    initMode |=> !secTick);

  // R9
  init_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initMode) && !$past(loadStrobe) |-> $stable(timeWord) && $stable(dateWord));

  // R8
  no_stray_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(initMode) && !secTick |-> $stable(timeWord) && $stable(dateWord) && $stable(initDone));

  // R2
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> !$stable(timeWord));

  // R10
  year_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone == (dateWord[23:16] != 8'h00));
endmodule

bind cal_bcd_top cal_bcd_chk chk (
  .clk(clk), .rstN(rstN), .initMode(initMode), .loadStrobe(loadStrobe),
  .timeWord(timeWord), .dateWord(dateWord), .secTick(secTick), .initDone(initDone)
);

// File: tb/cal_bcd_top_test.sv
module cal_bcd_top_test;
  logic clk = 0, rstN = 0, initMode = 0, loadStrobe = 0;
  logic [22:0] prescWord = 23'h0;
  logic [21:0] timeLoad = '0;
  logic [23:0] dateLoad = '0;
  logic [21:0] timeWord;
  logic [23:0] dateWord;
  logic secTick, initDone;
  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_bcd_top uut (.*);

  // behavioural model, decimal integers
  int mSec, mMin, mHr, mDay, mMon, mWd, mYr, pc;
  bit mTick;

  function automatic int bcd(int x); return ((x / 10) << 4) | (x % 10); endfunction
  function automatic int dec(int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int monLen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [21:0] tw(int h, int m, int s);
    return 22'((bcd(h) << 16) | (bcd(m) << 8) | bcd(s));
  endfunction
  function automatic logic [23:0] dw(int y, int wd, int mo, int d);
    return 24'((bcd(y) << 16) | (wd << 13) | (bcd(mo) << 8) | bcd(d));
  endfunction

  task automatic step();
    mSec++;
    if (mSec < 60) return;
    mSec = 0; mMin++;
    if (mMin < 60) return;
    mMin = 0; mHr++;
    if (mHr < 24) return;
    mHr = 0;
    mWd = (mWd == 7) ? 1 : mWd + 1;
    mDay++;
    if (mDay <= monLen(mMon, mYr)) return;
    mDay = 1; mMon++;
    if (mMon <= 12) return;
    mMon = 1; mYr = (mYr + 1) % 100;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSec = 0; mMin = 0; mHr = 0; mDay = 1; mMon = 1; mWd = 1; mYr = 0; pc = 0; mTick = 0;
    end else begin
      mTick = 0;
      if (initMode) begin
        pc = 0;
        if (loadStrobe) begin
          mSec = dec(int'(timeLoad[6:0])); mMin = dec(int'(timeLoad[14:8]));
          mHr = dec(int'(timeLoad[21:16])); mDay = dec(int'(dateLoad[5:0]));
          mMon = dec(int'(dateLoad[12:8])); mWd = int'(dateLoad[15:13]);
          mYr = dec(int'(dateLoad[23:16]));
        end
      end else begin
        pc++;
        if (pc == (int'(prescWord[22:16]) + 1) * (int'(prescWord[14:0]) + 1)) begin
          pc = 0; step(); mTick = 1;
        end
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    cmp("time", 32'(timeWord), 32'(tw(mHr, mMin, mSec)));
    cmp("date", 32'(dateWord), 32'(dw(mYr, mWd, mMon, mDay)));
    cmp("tick", 32'(secTick), 32'(mTick));
    cmp("flag", 32'(initDone), 32'(mYr != 0));
  end

  task automatic run(int n); repeat (n) @(negedge clk); endtask
  task automatic setPresc(int a, int s); prescWord = 23'((a << 16) | s); endtask
  task automatic loadCal(logic [21:0] t, logic [23:0] d);
    initMode = 1; timeLoad = t; dateLoad = d; loadStrobe = 1;
    run(1); loadStrobe = 0; run(3); initMode = 0;
  endtask

  initial begin
    setPresc(1, 2);
    run(3); rstN = 1;
    phase = "R1";
    checks++;
    if (timeWord !== 22'h0 || dateWord !== 24'h002101 || initDone !== 0 || secTick !== 0) begin
      errors++;
      $display("FAIL R1 reset actual %h %h %b %b expected 000000 002101 0 0",
               timeWord, dateWord, initDone, secTick);
    end
    run(1);
    phase = "R2"; run(40);
    phase = "R8"; timeLoad = tw(12, 34, 56); dateLoad = dw(50, 3, 6, 15);
    loadStrobe = 1; run(1); loadStrobe = 0; run(8);
    phase = "R9"; initMode = 1; run(15); initMode = 0; run(14);
    phase = "R10"; loadCal(tw(23, 59, 58), dw(24, 7, 2, 28));
    phase = "R5"; run(20);
    loadCal(tw(23, 59, 59), dw(24, 4, 2, 29)); run(10);
    loadCal(tw(23, 59, 59), dw(23, 2, 2, 28)); run(10);
    phase = "R4"; loadCal(tw(23, 59, 59), dw(21, 2, 4, 30)); run(10);
    loadCal(tw(23, 59, 59), dw(21, 5, 1, 31)); run(10);
    loadCal(tw(23, 59, 59), dw(21, 6, 9, 30)); run(10);
    phase = "R6"; loadCal(tw(23, 59, 59), dw(99, 7, 12, 31)); run(10);
    phase = "R7"; loadCal(tw(23, 59, 58), dw(41, 6, 3, 9)); run(20);
    phase = "R3"; initMode = 1; setPresc(0, 0); run(1);
    loadCal(tw(23, 58, 30), dw(30, 7, 11, 30)); run(160);
    phase = "R2"; initMode = 1; setPresc(3, 4); run(2); initMode = 0; run(100);
    phase = "R10"; loadCal(tw(1, 2, 3), dw(0, 1, 1, 1)); run(10);
    loadCal(tw(1, 2, 3), dw(7, 1, 1, 1)); run(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule